// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Front End

This block sits at the front of a single-port synchronous SRAM. The SRAM has one shared data bus and a small behavioural word array. On every rising clock edge the block samples three chip selects, two address strobes, a burst-advance input and the write controls: a global write, a byte-write enable and one write strobe per byte lane. From these it decides whether the edge starts a new access, continues the current one, ends it, or does nothing. The host-side strobe outranks the controller-side strobe. The two strobes also differ in write timing. A host-strobe access always loads its address as a read-style cycle, and any write data is taken one edge later. A controller-strobe access can write in the same edge that loads the address.

A two-bit burst counter is seeded from the low address bits. It produces four addresses, then wraps back to the start. The order is linear or interleaved, chosen live by an order input. When nothing drives that input, the board-level weak pull-up makes it select interleaved order. The bus is split into an input word, an output word and a drive enable for the pad. The drive enable is removed at once whenever the current cycle will write, whatever the output enable says.

Top module: `sbram_front`

## Requirements
- R1: An access starts only at an edge where `en0_n` is 0, `en1` is 1, `en2_n` is 0 and at least one strobe (`hstrb_n` or `cstrb_n`) is 0. With any select inactive, `core_addr` and the array are left unchanged.
- R2: A host-strobe start (`hstrb_n`=0) loads `addr_i` and ignores every write control at that edge. At the following edge, with no strobe low, the write controls decide whether a write happens, and `dq_in` is captured at that edge.
- R3: A controller-strobe start (`cstrb_n`=0, `hstrb_n`=1) whose write controls request a write stores `dq_in` at `addr_i` in the same edge that loads `addr_i`.
- R4: When both strobes are low at the same edge, the cycle behaves as a host-strobe start: the address is loaded and nothing is written.
- R5: Write strobe `bw_n[i]` (active low) gates lane i, which is data bits [8i+7:8i]. Lane 0 is bits 7:0. Lanes not selected keep their old contents.
- R6: `gw_n`=0 writes all four lanes. Otherwise a write needs `bwe_n`=0 and at least one `bw_n` bit at 0. Any other combination makes the cycle a read.
- R7: `dq_drive` is 0 in any cycle whose inputs will cause a write at the next edge (a controller start or a continuation that requests a write). This holds even when `oe_n` is 0. `dq_drive` also stays 0 after the write edge until a new read cycle.
- R8: After an edge that performs a read cycle (a host start, or a controller start or continuation without write), `dq_out` holds the word at `core_addr` and `dq_drive` equals NOT `oe_n` for the next cycle.
- R9: With `order_i`=0 the low two address bits run start, start+1, start+2, start+3 modulo 4.
- R10: With `order_i`=1 the low two address bits run start XOR 0, 1, 2, 3.
- R11: With `order_i` undriven (weakly pulled high), the sequence is the interleaved one.
- R12: During an active access with no strobe low, `adv_n`=0 advances one beat per edge and `adv_n`=1 holds the address. After the fourth beat the sequence wraps to the start address.
- R13: An edge with a strobe low while the selects are inactive ends the access. Afterwards `dq_drive` is 0, and write controls in strobe-free cycles change nothing until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en0_n | input | 1 | Chip select, active low |
| en1 | input | 1 | Chip select, active high |
| en2_n | input | 1 | Chip select, active low |
| hstrb_n | input | 1 | Host-side address strobe, active low, higher priority |
| cstrb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_i | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 or undriven interleaved |
| dq_in | input | LANES*LANE_W | Data from the shared bus |
| dq_out | output | LANES*LANE_W | Data toward the shared bus |
| dq_drive | output | 1 | Pad drive enable for `dq_out` |
| core_addr | output | ADDR_W | Address presented to the array |

## Verification
An address register or burst counter in the wrong state shows on `core_addr` in the cycle right after the faulty edge, and on `dq_out` in that same cycle. A write taken at the wrong edge or on the wrong lanes is visible only when the word is read back. It appears one cycle after the host start that reloads that address. An error in the write decode or the read flag shows at once on `dq_drive`, within the cycle whose inputs request the write, before any edge.

// File: rtl/sbram_pkg.sv
package sbram_pkg;

   // Kind of cycle decoded from the sampled control inputs.
   typedef enum logic [1:0] {
      CYC_NONE = 2'd0,   // idle or deselect
      CYC_HOST = 2'd1,   // host-strobe start
      CYC_CTL  = 2'd2,   // controller-strobe start
      CYC_CONT = 2'd3    // strobe-free cycle inside an access
   } cyc_e;

endpackage

// File: rtl/sbram_strobe_dec.sv
module sbram_strobe_dec
   import sbram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             en0_n,
   input  logic             en1,
   input  logic             en2_n,
   input  logic             hstrb_n,
   input  logic             cstrb_n,
   input  logic             adv_n,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   input  logic             active,
   output cyc_e             cyc,
   output logic             deselect,
   output logic             wr_req,
   output logic             adv_go,
   output logic [LANES-1:0] lane_mask
);

   logic sel_ok;

   always_comb begin
      sel_ok   = !en0_n && en1 && !en2_n;
      deselect = !sel_ok && !(hstrb_n && cstrb_n);

      // The host strobe outranks the controller strobe.
      if (sel_ok && !hstrb_n)
         cyc = CYC_HOST;
      else if (sel_ok && !cstrb_n)
         cyc = CYC_CTL;
      else if (active && hstrb_n && cstrb_n)
         cyc = CYC_CONT;
      else
         cyc = CYC_NONE;

      // The global write covers every lane; the byte path needs its enable.
      if (!gw_n)
         lane_mask = '1;
      else if (!bwe_n)
         lane_mask = ~bw_n;
      else
         lane_mask = '0;

      wr_req = |lane_mask;
      adv_go = (cyc == CYC_CONT) && !adv_n;
   end

endmodule

// File: rtl/sbram_burst_seq.sv
module sbram_burst_seq #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              adv,
   input  logic              interleave,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int UP_W = ADDR_W - BURST_W;

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] low;

   if (BURST_W < 1) begin : g_chk_burst
      $error("BURST_W must be at least 1");
   end
   if (UP_W < 0) begin : g_chk_span
      $error("ADDR_W must not be smaller than BURST_W");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         base_q <= load_addr;
         cnt_q  <= '0;
      end else if (adv) begin
         cnt_q  <= cnt_q + 1'b1;   // natural wrap after the last beat
      end
   end

   // The order input is applied live to the beat offset.
   always_comb begin
      if (interleave)
         low = base_q[BURST_W-1:0] ^ cnt_q;
      else
         low = base_q[BURST_W-1:0] + cnt_q;
   end

   if (UP_W > 0) begin : g_upper
      assign addr_o = {base_q[ADDR_W-1:BURST_W], low};
   end else begin : g_no_upper
      assign addr_o = low;
   end

   // R12: the final beat rolls back to offset zero
   p_wrap_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && (cnt_q == '1)) |=> (cnt_q == '0));

   // R12: without advance or load the burst state holds
   p_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> ($stable(cnt_q) && $stable(base_q)));

endmodule

// File: rtl/sbram_lane_array.sv
module sbram_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES-1:0]        lane_we,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W > 12) begin : g_chk_depth
      $error("ADDR_W too large for the behavioural array");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[g])
            cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[rd_addr];
   end

endmodule

// File: rtl/sbram_front.sv
module sbram_front
   import sbram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 4,
   parameter int LANE_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en0_n,
   input  logic                    en1,
   input  logic                    en2_n,
   input  logic                    hstrb_n,
   input  logic                    cstrb_n,
   input  logic                    adv_n,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    gw_n,
   input  logic                    bwe_n,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    oe_n,
   input  logic                    order_i,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_drive,
   output logic [ADDR_W-1:0]       core_addr
);

   localparam int DW = LANES * LANE_W;

   if (LANES < 1) begin : g_chk_lanes
      $error("LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_chk_lane_w
      $error("LANE_W must be at least 1");
   end

   cyc_e              cyc;
   logic              deselect;
   logic              wr_req;
   logic              adv_go;
   logic [LANES-1:0]  lane_mask;
   logic [LANES-1:0]  lane_we;
   logic              write_now;
   logic              load;
   logic              active_q;
   logic              rd_q;
   logic [ADDR_W-1:0] wr_addr;
   logic [DW-1:0]     rdata;

   sbram_strobe_dec #(.LANES(LANES)) dec_i (
      .en0_n     (en0_n),
      .en1       (en1),
      .en2_n     (en2_n),
      .hstrb_n   (hstrb_n),
      .cstrb_n   (cstrb_n),
      .adv_n     (adv_n),
      .gw_n      (gw_n),
      .bwe_n     (bwe_n),
      .bw_n      (bw_n),
      .active    (active_q),
      .cyc       (cyc),
      .deselect  (deselect),
      .wr_req    (wr_req),
      .adv_go    (adv_go),
      .lane_mask (lane_mask)
   );

   // Host starts never write; controller starts and continuations may.
   assign load      = (cyc == CYC_HOST) || (cyc == CYC_CTL);
   assign write_now = wr_req && ((cyc == CYC_CTL) || (cyc == CYC_CONT));
   assign lane_we   = write_now ? lane_mask : '0;
   assign wr_addr   = (cyc == CYC_CTL) ? addr_i : core_addr;

   sbram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_addr  (addr_i),
      .adv        (adv_go),
      .interleave (order_i),
      .addr_o     (core_addr)
   );

   sbram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) mem_i (
      .clk     (clk),
      .wr_addr (wr_addr),
      .lane_we (lane_we),
      .wdata   (dq_in),
      .rd_addr (core_addr),
      .rdata   (rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rd_q     <= 1'b0;
      end else begin
         if (load)
            active_q <= 1'b1;
         else if (deselect)
            active_q <= 1'b0;
         rd_q <= (cyc == CYC_HOST) ||
                 (((cyc == CYC_CTL) || (cyc == CYC_CONT)) && !wr_req);
      end
   end

   // A pending write releases the pad at once, whatever oe_n says.
   assign dq_drive = rd_q && !oe_n && !write_now;
   assign dq_out   = rdata;

   // R1: a start edge presents the sampled address to the array
   p_load_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (core_addr == $past(addr_i)));

   // R4: both strobes low never write
   p_both_strobes_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!hstrb_n && !cstrb_n) |-> (lane_we == '0));

   // R7: the pad is never driven while a lane write is being applied
   p_release_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (|lane_we) |-> !dq_drive);

   // R13: a deselect edge leaves the pad undriven
   p_quiet_r13 : assert property (@(posedge clk) disable iff (!rst_n)
      deselect |=> !dq_drive);

endmodule

// File: tb/sbram_front_tb_top.sv
`timescale 1ns/1ps
module sbram_front_tb_top;

   localparam int AW = 6;
   localparam int DW = 32;

   // {order, s0, s1, s2, s3}: expected low address bits per beat
   localparam logic [8:0] VEC [8] = '{
      9'b0_00_01_10_11, 9'b0_01_10_11_00, 9'b0_10_11_00_01, 9'b0_11_00_01_10,
      9'b1_00_01_10_11, 9'b1_01_00_11_10, 9'b1_10_11_00_01, 9'b1_11_10_01_00
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          en0_n, en1, en2_n, hstrb_n, cstrb_n, adv_n;
   logic [AW-1:0] addr_i;
   logic          gw_n, bwe_n, oe_n;
   logic [3:0]    bw_n;
   logic [DW-1:0] dq_in, dq_out;
   logic          dq_drive;
   logic [AW-1:0] core_addr;
   logic          order_oe, order_v;
   tri1           order_w;

   assign order_w = order_oe ? order_v : 1'bz;

   int n_chk = 0;
   int n_err = 0;
   logic [DW-1:0] model [64];

   always #2 clk = ~clk;

   sbram_front dut_i (
      .clk(clk), .rst_n(rst_n), .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
      .hstrb_n(hstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n), .addr_i(addr_i),
      .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .order_i(order_w),
      .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive), .core_addr(core_addr)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      hstrb_n = 1'b1; cstrb_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = 4'hF;
      en0_n = 1'b0; en1 = 1'b1; en2_n = 1'b0;
   endtask

   task automatic host_read(input int a);
      addr_i = AW'(a); hstrb_n = 1'b0;
      tick();
      idle(); oe_n = 1'b0;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      idle(); oe_n = 1'b1; addr_i = '0; dq_in = '0;
      order_oe = 1'b1; order_v = 1'b0; rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1; oe_n = 1'b0;
      #1;
      chk("reset core_addr", DW'(core_addr), '0);
      chk("reset dq_drive R8", DW'(dq_drive), '0);

      // Fill the array with controller-strobe writes (R3).
      for (int a = 0; a < 64; a++) begin
         addr_i = AW'(a); cstrb_n = 1'b0; gw_n = 1'b0;
         dq_in = 32'h5A000000 ^ (DW'(a) * 32'h00010203);
         model[a] = dq_in;
         tick();
         idle();
         #1;
         if (a < 3) chk("R3 same-edge write", dq_out, model[a]);
      end

      // Burst order table: R9 linear, R10 interleaved, R12 wrap.
      for (int i = 0; i < 8; i++) begin
         logic [1:0] s [4];
         logic [AW-1:0] exp_a;
         for (int k = 0; k < 4; k++) s[k] = VEC[i][7-2*k -: 2];
         order_v = VEC[i][8];
         host_read({4'b1011, s[0]});
         chk(VEC[i][8] ? "R10 beat0" : "R9 beat0", DW'(core_addr), DW'({4'b1011, s[0]}));
         chk("R8 read drive", DW'(dq_drive), 1);
         chk("R8 read data", dq_out, model[{4'b1011, s[0]}]);
         adv_n = 1'b0;
         for (int k = 1; k < 5; k++) begin
            tick();
            exp_a = {4'b1011, s[k % 4]};
            chk(k == 4 ? "R12 wrap" : (VEC[i][8] ? "R10 beat" : "R9 beat"),
                DW'(core_addr), DW'(exp_a));
            chk("R8 burst data", dq_out, model[exp_a]);
         end
         adv_n = 1'b1;
         tick();
         chk("R12 hold", DW'(core_addr), DW'({4'b1011, s[0]}));
      end

      // R11: undriven order input selects interleaved.
      order_oe = 1'b0;
      host_read(6'b0110_01);
      adv_n = 1'b0;
      tick();
      adv_n = 1'b1;
      #1;
      chk("R11 undriven interleaved", DW'(core_addr), DW'(6'b0110_00));
      order_oe = 1'b1; order_v = 1'b0;
      #1;
      chk("R9 live linear", DW'(core_addr), DW'(6'b0110_10));

      // R2: host start ignores write controls; data taken at next edge.
      addr_i = 6'd5; hstrb_n = 1'b0; gw_n = 1'b0; dq_in = 32'hDEAD0001;
      tick();
      idle(); oe_n = 1'b0;
      #1;
      chk("R2 no write at host edge", dq_out, model[5]);
      chk("R2 host edge is read R8", DW'(dq_drive), 1);
      gw_n = 1'b0; dq_in = 32'hCAFE0005;
      #1;
      chk("R7 release with oe_n low", DW'(dq_drive), 0);
      tick();
      idle();
      #1;
      model[5] = 32'hCAFE0005;
      chk("R2 write at second edge", dq_out, model[5]);
      chk("R7 stays released", DW'(dq_drive), 0);

      // R4: both strobes low behave as host start.
      addr_i = 6'd9; hstrb_n = 1'b0; cstrb_n = 1'b0; gw_n = 1'b0; dq_in = 32'hBAD00009;
      tick();
      idle();
      #1;
      chk("R4 address loaded", DW'(core_addr), 32'd9);
      chk("R4 no write", dq_out, model[9]);

      // R5: per-lane masks (bw_n bit i gates bits 8i+7:8i).
      addr_i = 6'd12; cstrb_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1010; dq_in = 32'hA1B2C3D4;
      tick();
      idle();
      #1;
      model[12] = {model[12][31:24], 8'hB2, model[12][15:8], 8'hD4};
      chk("R5 lanes 0 and 2", dq_out, model[12]);
      bwe_n = 1'b0; bw_n = 4'b0111; dq_in = 32'h99887766;
      tick();
      idle();
      #1;
      model[12] = {8'h99, model[12][23:0]};
      chk("R5 lane 3 by continuation", dq_out, model[12]);

      // R6: write decode.
      addr_i = 6'd13; cstrb_n = 1'b0; bwe_n = 1'b1; bw_n = 4'h0; dq_in = 32'h0BAD0BAD;
      tick();
      idle(); oe_n = 1'b0;
      #1;
      chk("R6 strobes without enable read", dq_out, model[13]);
      chk("R6 read cycle drives", DW'(dq_drive), 1);
      addr_i = 6'd13; cstrb_n = 1'b0; bwe_n = 1'b0; bw_n = 4'hF;
      tick();
      idle();
      #1;
      chk("R6 enable without strobes read", dq_out, model[13]);
      addr_i = 6'd13; cstrb_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; dq_in = 32'h0F0F0F0F;
      tick();
      idle();
      #1;
      model[13] = 32'h0F0F0F0F;
      chk("R6 global write all lanes", dq_out, model[13]);

      // R8: oe_n gates the drive after a read.
      host_read(13);
      oe_n = 1'b1;
      #1;
      chk("R8 oe_n high no drive", DW'(dq_drive), 0);
      oe_n = 1'b0;
      #1;
      chk("R8 oe_n low drive", DW'(dq_drive), 1);

      // R1: each inactive select blocks a start.
      for (int e = 0; e < 3; e++) begin
         en0_n = (e == 0); en1 = (e != 1); en2_n = (e == 2);
         addr_i = 6'd20; cstrb_n = 1'b0; gw_n = 1'b0; dq_in = 32'hFFFF0000;
         tick();
         idle();
         #1;
         chk("R1 no load with select off", DW'(core_addr), 32'd13);
         chk("R13 deselect no drive", DW'(dq_drive), 0);
      end
      en1 = 1'b0; addr_i = 6'd21; hstrb_n = 1'b0;
      tick();
      idle();
      #1;
      chk("R1 host strobe blocked", DW'(core_addr), 32'd13);
      host_read(20);
      chk("R1 no write with select off", dq_out, model[20]);

      // R13: after a deselect, continuation writes are dropped.
      en1 = 1'b0; hstrb_n = 1'b0; addr_i = 6'd30;
      tick();
      idle(); gw_n = 1'b0; dq_in = 32'h13131313;
      tick();
      idle();
      host_read(20);
      chk("R13 write after deselect ignored", dq_out, model[20]);

      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule